// File: doc/BRIEF.md
# Read-Ordering Bridge for Mixed-Latency Targets

This block sits between one pipelined memory-mapped read master and two read targets. One target always returns data a fixed number of cycles after it takes a read. The other target has a latency that varies and flags its returned data with its own valid strobe. One address bit picks the target. The bridge passes accepted reads through and keeps a count of outstanding reads for each target. It then merges the two response streams back onto the master's data and valid lines.

Responses have to reach the master in the order the reads were accepted. Without the bridge, a late response from the variable target can land on the same cycle as an early response from the fixed target, and one of the two is lost. To prevent this, the bridge holds the master in waitrequest whenever a read names a different target than the one that still has reads in flight. At any moment only one target owns outstanding reads, so the two response streams can never overlap or overtake each other. Reads that go to the same target as the previous read stream through with no added wait.

Top module: `rd_order_bridge`

## Requirements
- R1: After synchronous reset, with no read requested, the master waitrequest, the master data-valid and both target read strobes are low.
- R2: Address bit SEL_BIT selects the target: 0 selects the fixed-latency target, 1 selects the variable-latency target. The read strobe is raised only toward the selected target, and the address is passed unchanged to both targets.
- R3: A read accepted by the fixed target in cycle t produces exactly one master data-valid pulse in cycle t+FIX_LAT (2 by default), carrying the fixed target's read data from that cycle.
- R4: Each data-valid pulse from the variable target is forwarded to the master in the same cycle, with that target's read data.
- R5: Consecutive reads to the same target are accepted back to back with no added wait cycles, as long as that target has fewer than MAX_OUT reads outstanding.
- R6: A read to the other target is held with waitrequest high, and no read strobe is raised, until every read outstanding at the previous target has returned. It is accepted in the cycle after that target's last data-valid. This applies in both directions.
- R7: While the selected target asserts its own waitrequest, the master sees waitrequest high and the strobe toward that target stays raised.
- R8: When a target has MAX_OUT (8 by default) reads outstanding, a further read to it is held until one of them returns. Its counter never wraps.
- R9: Every accepted read yields exactly one master data-valid pulse. Pulses arrive in acceptance order, and the two targets never both hold outstanding reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_addr | input | ADDR_W | Master read address |
| m_read | input | 1 | Master read request |
| m_waitrequest | output | 1 | Holds the master's current request |
| m_readdata | output | DATA_W | Merged read data to master |
| m_readdatavalid | output | 1 | Merged data-valid to master |
| s_addr | output | ADDR_W | Address presented to both targets |
| fx_read | output | 1 | Read strobe to fixed-latency target |
| fx_waitrequest | input | 1 | Stall from fixed-latency target |
| fx_readdata | input | DATA_W | Data from fixed-latency target |
| vr_read | output | 1 | Read strobe to variable-latency target |
| vr_waitrequest | input | 1 | Stall from variable-latency target |
| vr_readdata | input | DATA_W | Data from variable-latency target |
| vr_readdatavalid | input | 1 | Data-valid from variable-latency target |

## Verification
A fixed-target response is due exactly FIX_LAT cycles after its acceptance cycle. A variable-target response is due in the same cycle the target raises its valid. A switched read is due to be accepted in the cycle after the previous target's last response. The driver records the acceptance cycle of every read and queues the expected data together with the due cycle. The monitor pops one queue entry per data-valid and compares both the data and the cycle. All sampling happens just before the rising edge, and inputs change only on the falling edge, so every comparison sees the settled values of the cycle it checks. The directed switch, stall and saturation tests also compare the exact number of wait cycles with the count derived from these latencies.

// File: rtl/rd_order_pkg.sv
package rd_order_pkg;

    localparam int NUM_TGT = 2;

    typedef enum logic {
        TGT_FIXED = 1'b0,
        TGT_VAR   = 1'b1
    } tgt_e;

    function automatic tgt_e tgt_of(input logic sel_bit);
        return sel_bit ? TGT_VAR : TGT_FIXED;
    endfunction

endpackage

// File: rtl/rob_fixed_lat_pipe.sv
module rob_fixed_lat_pipe #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    output logic valid
);

    logic [LAT-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= (stage_q << 1) | LAT'(accept);
    end

    assign valid = stage_q[LAT-1];

endmodule

// File: rtl/rob_out_ctr.sv
module rob_out_ctr #(
    parameter int MAX_OUT = 8,
    parameter int CNT_W   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic busy,
    output logic full
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign busy = (count_q != '0);
    assign full = (count_q == CNT_W'(MAX_OUT));

    // R8: a new read may never be accepted on top of a full count
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec) |-> (count_q < CNT_W'(MAX_OUT)));

    // R9: every returned response must belong to an outstanding read
    assert_no_orphan_resp_R9: assert property (@(posedge clk) disable iff (rst)
        dec |-> (count_q != '0));

endmodule

// File: rtl/rob_resp_mux.sv
module rob_resp_mux #(
    parameter int NT     = 2,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NT-1:0]            vld_i,
    input  logic [NT-1:0][DATA_W-1:0] dat_i,
    output logic                     vld_o,
    output logic [DATA_W-1:0]        dat_o
);

    always_comb begin
        dat_o = '0;
        for (int i = 0; i < NT; i++) begin
            if (vld_i[i]) dat_o = dat_o | dat_i[i];
        end
    end

    assign vld_o = |vld_i;

    // R9: two targets returning in the same cycle would lose a response
    assert_no_collision_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(vld_i));

endmodule

// File: rtl/rd_order_bridge.sv
module rd_order_bridge
    import rd_order_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int SEL_BIT = 15,
    parameter int FIX_LAT = 2,
    parameter int MAX_OUT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic              m_read,
    output logic              m_waitrequest,
    output logic [DATA_W-1:0] m_readdata,
    output logic              m_readdatavalid,
    output logic [ADDR_W-1:0] s_addr,
    output logic              fx_read,
    input  logic              fx_waitrequest,
    input  logic [DATA_W-1:0] fx_readdata,
    output logic              vr_read,
    input  logic              vr_waitrequest,
    input  logic [DATA_W-1:0] vr_readdata,
    input  logic              vr_readdatavalid
);

    localparam int CNT_W = $clog2(MAX_OUT + 1);

    tgt_e                            req_tgt;
    tgt_e                            last_tgt;
    logic [NUM_TGT-1:0]              busy;
    logic [NUM_TGT-1:0]              full;
    logic [NUM_TGT-1:0]              dn_wait;
    logic [NUM_TGT-1:0]              strobe;
    logic [NUM_TGT-1:0]              acc;
    logic [NUM_TGT-1:0]              rsp_v;
    logic [NUM_TGT-1:0][DATA_W-1:0]  rsp_d;
    logic                            fx_vld;
    logic                            switch_blk;
    logic                            stall;

    // target decode and ordering gate
    assign req_tgt    = tgt_of(m_addr[SEL_BIT]);
    assign dn_wait    = {vr_waitrequest, fx_waitrequest};
    assign switch_blk = (req_tgt != last_tgt) && busy[last_tgt];
    assign stall      = m_read && (switch_blk || full[req_tgt]);

    assign m_waitrequest = stall || (m_read && dn_wait[req_tgt]);
    assign strobe        = (m_read && !stall) ? (NUM_TGT'(1) << req_tgt) : '0;
    assign acc           = strobe & ~dn_wait;

    assign s_addr  = m_addr;
    assign fx_read = strobe[TGT_FIXED];
    assign vr_read = strobe[TGT_VAR];

    always_ff @(posedge clk) begin
        if (rst)       last_tgt <= TGT_FIXED;
        else if (|acc) last_tgt <= req_tgt;
    end

    // response timing of the fixed-latency target
    rob_fixed_lat_pipe #(.LAT(FIX_LAT)) u_fx_pipe (
        .clk    (clk),
        .rst    (rst),
        .accept (acc[TGT_FIXED]),
        .valid  (fx_vld)
    );

    assign rsp_v = {vr_readdatavalid, fx_vld};
    assign rsp_d = {vr_readdata, fx_readdata};

    // one outstanding-read counter per target
    for (genvar g = 0; g < NUM_TGT; g++) begin : g_ctr
        rob_out_ctr #(.MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_ctr (
            .clk  (clk),
            .rst  (rst),
            .inc  (acc[g]),
            .dec  (rsp_v[g]),
            .busy (busy[g]),
            .full (full[g])
        );
    end

    rob_resp_mux #(.NT(NUM_TGT), .DATA_W(DATA_W)) u_mux (
        .clk   (clk),
        .rst   (rst),
        .vld_i (rsp_v),
        .dat_i (rsp_d),
        .vld_o (m_readdatavalid),
        .dat_o (m_readdata)
    );

    // R9: ownership of in-flight reads is exclusive
    assert_single_owner_R9: assert property (@(posedge clk) disable iff (rst)
        !(busy[TGT_FIXED] && busy[TGT_VAR]));

    // R2: never both strobes at once
    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        !(fx_read && vr_read));

    // R1: an idle master is never stalled
    assert_idle_no_wait_R1: assert property (@(posedge clk) disable iff (rst)
        !m_read |-> !m_waitrequest);

endmodule

// File: tb/rd_order_bridge_tb.sv
`timescale 1ns/1ps
module rd_order_bridge_tb;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] m_addr;
    logic              m_read;
    logic              m_waitrequest;
    logic [DATA_W-1:0] m_readdata;
    logic              m_readdatavalid;
    logic [ADDR_W-1:0] s_addr;
    logic              fx_read;
    logic              fx_waitrequest;
    logic [DATA_W-1:0] fx_readdata;
    logic              vr_read;
    logic              vr_waitrequest;
    logic [DATA_W-1:0] vr_readdata;
    logic              vr_readdatavalid;

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    rd_order_bridge u_dut (
        .clk(clk), .rst(rst), .m_addr(m_addr), .m_read(m_read),
        .m_waitrequest(m_waitrequest), .m_readdata(m_readdata),
        .m_readdatavalid(m_readdatavalid), .s_addr(s_addr),
        .fx_read(fx_read), .fx_waitrequest(fx_waitrequest), .fx_readdata(fx_readdata),
        .vr_read(vr_read), .vr_waitrequest(vr_waitrequest), .vr_readdata(vr_readdata),
        .vr_readdatavalid(vr_readdatavalid)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [DATA_W-1:0] data_of(input logic [ADDR_W-1:0] a);
        return {~a, a};
    endfunction

    typedef struct {
        logic [DATA_W-1:0] d;
        bit                fixed;
        int                due;
    } exp_t;
    exp_t expq[$];

    // target models
    int                var_lat  = 4;
    int                last_due = 0;
    logic [ADDR_W-1:0] vq_addr[$];
    int                vq_due[$];
    logic [DATA_W-1:0] st1 = '0, st2 = '0;

    initial begin
        fx_readdata      = '0;
        fx_waitrequest   = 1'b0;
        vr_readdata      = '0;
        vr_readdatavalid = 1'b0;
        forever begin
            @(negedge clk);
            fx_readdata = st2;
            if (vq_due.size() > 0 && vq_due[0] == cyc) begin
                vr_readdatavalid = 1'b1;
                vr_readdata      = data_of(vq_addr[0]);
                void'(vq_addr.pop_front());
                void'(vq_due.pop_front());
            end else begin
                vr_readdatavalid = 1'b0;
                vr_readdata      = '0;
            end
            #3;
            st2 = st1;
            st1 = (fx_read && !fx_waitrequest) ? data_of(s_addr) : '0;
            if (vr_read && !vr_waitrequest) begin
                int d;
                d = cyc + var_lat;
                if (d <= last_due) d = last_due + 1;
                last_due = d;
                vq_addr.push_back(s_addr);
                vq_due.push_back(d);
            end
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (!rst && m_readdatavalid) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R9 response without accepted read", 1, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(m_readdata == e.d, "R9 response order/data", m_readdata, e.d);
                    if (e.fixed) chk(cyc == e.due, "R3 fixed latency cycle", cyc, e.due);
                    else         chk(vr_readdatavalid == 1'b1, "R4 same-cycle forward",
                                     vr_readdatavalid, 1);
                end
            end
        end
    end

    // driver
    task automatic rd(input logic [ADDR_W-1:0] a, output int stalls, output int bad_strobe);
        @(negedge clk);
        m_read = 1'b1;
        m_addr = a;
        stalls = 0;
        bad_strobe = 0;
        #3;
        while (m_waitrequest) begin
            stalls++;
            if ((fx_read || vr_read) && !(a[15] && vr_waitrequest)) bad_strobe++;
            @(negedge clk);
            #3;
        end
        chk(a[15] ? (vr_read && !fx_read) : (fx_read && !vr_read), "R2 strobe select",
            {fx_read, vr_read}, a[15] ? 1 : 2);
        chk(s_addr == a, "R2 address pass", s_addr, a);
        expq.push_back('{d: data_of(a), fixed: !a[15], due: cyc + 2});
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        m_read = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R9 actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int st, bs, tot;
        rst = 1'b1;
        m_read = 1'b0;
        m_addr = '0;
        vr_waitrequest = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #3;
        // R1 reset state
        chk(!m_waitrequest, "R1 waitrequest idle", m_waitrequest, 0);
        chk(!m_readdatavalid, "R1 valid idle", m_readdatavalid, 0);
        chk(!fx_read && !vr_read, "R1 strobes idle", {fx_read, vr_read}, 0);

        // R5 + R3: back-to-back fixed-target reads
        tot = 0;
        for (int i = 0; i < 4; i++) begin
            rd(16'h0010 + 16'(i), st, bs);
            tot += st;
        end
        chk(tot == 0, "R5 fixed stream no wait", tot, 0);
        idle(6);

        // R5 + R4: back-to-back variable-target reads
        var_lat = 4;
        tot = 0;
        for (int i = 0; i < 4; i++) begin
            rd(16'h8000 + 16'(i), st, bs);
            tot += st;
        end
        chk(tot == 0, "R5 variable stream no wait", tot, 0);
        idle(10);

        // R6: switch variable -> fixed
        var_lat = 6;
        rd(16'h8100, st, bs);
        rd(16'h0020, st, bs);
        chk(st == 6, "R6 switch var->fixed wait cycles", st, 6);
        chk(bs == 0, "R6 no strobe while held", bs, 0);
        chk(vq_due.size() == 0, "R6 previous target drained", vq_due.size(), 0);
        // R6: switch fixed -> variable
        rd(16'h0021, st, bs);
        rd(16'h8101, st, bs);
        chk(st == 2, "R6 switch fixed->var wait cycles", st, 2);
        chk(bs == 0, "R6 no strobe while held (reverse)", bs, 0);
        idle(12);

        // R7: downstream waitrequest passes through
        var_lat = 3;
        @(negedge clk);
        vr_waitrequest = 1'b1;
        fork
            rd(16'h8200, st, bs);
            begin
                repeat (3) @(negedge clk);
                vr_waitrequest = 1'b0;
            end
        join
        chk(st == 2, "R7 downstream wait cycles", st, 2);
        idle(10);

        // R8: saturation at MAX_OUT
        var_lat = 20;
        tot = 0;
        for (int i = 0; i < 8; i++) begin
            rd(16'h8300 + 16'(i), st, bs);
            tot += st;
        end
        chk(tot == 0, "R8 first eight accepted freely", tot, 0);
        rd(16'h8308, st, bs);
        chk(st == 13, "R8 ninth held until a return", st, 13);
        chk(bs == 0, "R8 no strobe while full", bs, 0);
        idle(50);

        // R9: mixed ordering stress
        for (int i = 0; i < 24; i++) begin
            logic [11:0] pat;
            pat = 12'b1011_0011_1010;
            var_lat = (i % 3 == 0) ? 5 : 3;
            rd({pat[i % 12], 7'd0, 8'(i)}, st, bs);
        end
        idle(60);
        chk(expq.size() == 0, "R9 every read answered", expq.size(), 0);
        chk(vq_due.size() == 0, "R9 variable target drained", vq_due.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule